// File: doc/BRIEF.md
# Branch Trace Encoder

This block shrinks a processor's execution trace down to the events that a decoder cannot work out from the program image on its own. Straight-line code and direct jumps produce nothing. Each retired conditional branch adds one taken/not-taken bit to a running map. Indirect jumps and traps each produce one message that carries the target address.

The core reports one strobe per event class: a conditional branch with its outcome, an indirect jump, or a trap. A separate address bus carries the target for the address-bearing events. Messages are fixed-width words with a 3-bit type header. They leave through a valid/ready channel backed by a small FIFO. If the downstream sink stalls long enough for the FIFO to fill, new messages are discarded. A single loss notice, carrying the number of discarded messages, is queued once a slot is free again.

Top module: `branch_trace_encoder`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `msg_valid` is 0, and the branch map starts empty.
- R2: The k-th conditional branch since the last emitted message (k counted from 0) stores its outcome (1 = taken) at map bit k. The 16th such branch causes a map message to be visible on the output one cycle after that branch's strobe is sampled. This message has header 3'b001, count 16, the full map, and an address field of 0.
- R3: Fewer than 16 pending branches, with no indirect jump and no trap, produce no message.
- R4: An indirect jump produces a message with header 3'b010. It carries the pending branch count (0 to 15), the pending map with unused bits at 0, and the 32-bit target from `evt_addr`. It then clears the branch map and count.
- R5: A trap produces a message with header 3'b011 and the same count, map and address content as R4. It also clears the pending branches.
- R6: Message word layout: bits [55:53] header, [52:48] branch count, [47:32] branch map, [31:0] address.
- R7: Messages leave in the order they were generated. While `msg_valid` is 1 and `msg_ready` is 0, `msg_data` holds its value.
- R8: A message generated while the FIFO is full is discarded. When a slot next frees, one loss message is queued behind the messages already held. It has header 3'b100 and a count equal to the number of messages discarded, saturating at 31. Its map and address are 0. After the notice, normal messages are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A conditional branch retired this cycle |
| br_taken | input | 1 | Outcome of that branch, 1 = taken |
| ind_valid | input | 1 | An indirect jump retired this cycle |
| trap_valid | input | 1 | A trap was taken this cycle |
| evt_addr | input | 32 | Target address for an indirect jump or a trap |
| msg_valid | output | 1 | A message is available |
| msg_ready | input | 1 | The sink accepts the message this cycle |
| msg_data | output | 56 | Message word, layout per R6 |

## Verification
The checks assume that the core raises at most one of the three event strobes in any cycle. A superscalar retire would need a wider front end, so this is treated as an input rule and checked as such. The directed stimulus pulses one strobe per cycle and never overlaps them. The stability check on `msg_data` assumes the sink withdraws `msg_ready` only between transfers. The bench changes `msg_ready` only at falling edges.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam int unsigned MAP_W  = 16;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = $clog2(MAP_W);
  localparam int unsigned CNT_W  = $clog2(MAP_W + 1);

  typedef enum logic [2:0] {
    HDR_MAP  = 3'b001,
    HDR_IND  = 3'b010,
    HDR_TRAP = 3'b011,
    HDR_OVF  = 3'b100
  } hdr_e;

  typedef struct packed {
    hdr_e              hdr;
    logic [CNT_W-1:0]  cnt;
    logic [MAP_W-1:0]  map;
    logic [ADDR_W-1:0] addr;
  } msg_t;

  localparam int unsigned MSG_W = $bits(msg_t);
endpackage

// File: rtl/bte_packer.sv
module bte_packer
  import bte_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic              ind_valid,
  input  logic              trap_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              gen_valid,
  output msg_t              gen_msg
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [MAP_W-1:0] map_q, map_d, map_ins;

  always_comb begin
    map_ins = map_q;
    map_ins[cnt_q[IDX_W-1:0]] = br_taken;
    gen_valid = 1'b0;
    gen_msg   = '0;
    cnt_d     = cnt_q;
    map_d     = map_q;
    if (trap_valid || ind_valid) begin
      gen_valid    = 1'b1;
      gen_msg.hdr  = trap_valid ? HDR_TRAP : HDR_IND;
      gen_msg.cnt  = cnt_q;
      gen_msg.map  = map_q;
      gen_msg.addr = evt_addr;
      cnt_d        = '0;
      map_d        = '0;
    end else if (br_valid) begin
      if (cnt_q == CNT_W'(MAP_W - 1)) begin
        gen_valid   = 1'b1;
        gen_msg.hdr = HDR_MAP;
        gen_msg.cnt = CNT_W'(MAP_W);
        gen_msg.map = map_ins;
        cnt_d       = '0;
        map_d       = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        map_d = map_ins;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      map_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      map_q <= map_d;
    end
  end

  // R4 R5
  addr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ind_valid || trap_valid) |=> (cnt_q == '0 && map_q == '0));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAP_W - 1));

  // R3
  quiet_below_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!ind_valid && !trap_valid && cnt_q != CNT_W'(MAP_W - 1)) |-> !gen_valid);
endmodule

// File: rtl/bte_loss.sv
module bte_loss
  import bte_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gen_valid,
  input  msg_t gen_msg,
  input  logic fifo_full,
  output logic push,
  output msg_t push_msg
);
  logic             lost_q;
  logic [CNT_W-1:0] drops_q;
  logic             ovf_go, take, drop;
  msg_t             ovf_msg;

  always_comb begin
    ovf_go      = lost_q && !fifo_full;
    take        = gen_valid && !fifo_full && !lost_q;
    drop        = gen_valid && !take;
    ovf_msg     = '0;
    ovf_msg.hdr = HDR_OVF;
    ovf_msg.cnt = drops_q;
    push        = ovf_go || take;
    push_msg    = ovf_go ? ovf_msg : gen_msg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q  <= 1'b0;
      drops_q <= '0;
    end else if (ovf_go) begin
      lost_q  <= drop;
      drops_q <= drop ? CNT_W'(1) : '0;
    end else if (drop) begin
      lost_q <= 1'b1;
      if (drops_q != '1) drops_q <= drops_q + 1'b1;
    end
  end

  // R8
  full_marks_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && fifo_full) |=> lost_q);

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !fifo_full);
endmodule

// File: rtl/bte_fifo.sv
module bte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [OCC_W-1:0] occ_q;

  assign full  = (occ_q == OCC_W'(DEPTH));
  assign empty = (occ_q == '0);
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R7
  occ_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(occ_q));
endmodule

// File: rtl/branch_trace_encoder.sv
module branch_trace_encoder
  import bte_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic              ind_valid,
  input  logic              trap_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [MSG_W-1:0]  msg_data
);
  logic gen_valid, push, full, empty, pop;
  msg_t gen_msg, push_msg;

  bte_packer u_packer (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
    .ind_valid(ind_valid), .trap_valid(trap_valid), .evt_addr(evt_addr),
    .gen_valid(gen_valid), .gen_msg(gen_msg)
  );

  bte_loss u_loss (
    .clk(clk), .rst(rst), .gen_valid(gen_valid), .gen_msg(gen_msg),
    .fifo_full(full), .push(push), .push_msg(push_msg)
  );

  bte_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_msg),
    .pop(pop), .full(full), .empty(empty), .head(msg_data)
  );

  assign msg_valid = !empty;
  assign pop       = msg_valid && msg_ready;

  // R7
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));

  // R4 input rule: one event class per cycle
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({br_valid, ind_valid, trap_valid}));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !msg_valid);
endmodule

// File: tb/branch_trace_encoder_bench.sv
module branch_trace_encoder_bench;
  import bte_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 0, br_taken = 0, ind_valid = 0, trap_valid = 0;
  logic [31:0] evt_addr = '0;
  logic msg_valid;
  logic msg_ready = 1'b1;
  logic [MSG_W-1:0] msg_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  branch_trace_encoder u_branch_trace_encoder (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
    .ind_valid(ind_valid), .trap_valid(trap_valid), .evt_addr(evt_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data)
  );

  function automatic logic [MSG_W-1:0] mk(logic [2:0] h, logic [4:0] c,
                                          logic [15:0] m, logic [31:0] a);
    return {h, c, m, a};
  endfunction

  task automatic check(bit ok, string req, logic [MSG_W-1:0] act, logic [MSG_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic br(bit t);
    br_valid = 1; br_taken = t;
    @(negedge clk);
    br_valid = 0; br_taken = 0;
  endtask

  task automatic ind(logic [31:0] a);
    ind_valid = 1; evt_addr = a;
    @(negedge clk);
    ind_valid = 0;
  endtask

  task automatic trap(logic [31:0] a);
    trap_valid = 1; evt_addr = a;
    @(negedge clk);
    trap_valid = 0;
  endtask

  task automatic expect_msg(string req, logic [MSG_W-1:0] exp);
    for (int w = 0; w < 4 && !msg_valid; w++) @(negedge clk);
    check(msg_valid, req, MSG_W'(msg_valid), MSG_W'(1));
    check(msg_data == exp, req, msg_data, exp);
    @(negedge clk);
  endtask

  task automatic expect_idle(string req);
    check(!msg_valid, req, MSG_W'(msg_valid), MSG_W'(0));
  endtask

  task automatic t_reset;
    expect_idle("R1 in reset");
    @(negedge clk); rst = 0;
    expect_idle("R1 after reset");
    @(negedge clk);
    expect_idle("R1 idle");
  endtask

  task automatic t_map_full;
    logic [15:0] pat = 16'hA5C3;
    for (int i = 0; i < 16; i++) begin
      br(pat[i]);
      if (i == 14) expect_idle("R3 15 branches pending");
    end
    expect_msg("R2 R6 full map", mk(3'b001, 5'd16, pat, 32'h0));
    expect_idle("R2 single map message");
  endtask

  task automatic t_indirect;
    br(1); br(0); br(1);
    expect_idle("R3 three branches pending");
    ind(32'h8000_1234);
    expect_msg("R4 indirect with map", mk(3'b010, 5'd3, 16'h0005, 32'h8000_1234));
    ind(32'h0000_0040);
    expect_msg("R4 map cleared", mk(3'b010, 5'd0, 16'h0, 32'h0000_0040));
  endtask

  task automatic t_trap;
    trap(32'h0000_0100);
    expect_msg("R5 trap empty map", mk(3'b011, 5'd0, 16'h0, 32'h0000_0100));
    for (int i = 0; i < 15; i++) br(1);
    expect_idle("R3 fifteen taken pending");
    trap(32'hFFFF_FFFC);
    expect_msg("R5 trap fifteen", mk(3'b011, 5'd15, 16'h7FFF, 32'hFFFF_FFFC));
    br(1);
    ind(32'h0000_2000);
    expect_msg("R5 trap cleared map", mk(3'b010, 5'd1, 16'h0001, 32'h0000_2000));
  endtask

  task automatic t_stall;
    msg_ready = 0;
    ind(32'hA000_0001);
    ind(32'hA000_0002);
    for (int i = 0; i < 3; i++) begin
      check(msg_valid && msg_data == mk(3'b010, 0, 0, 32'hA000_0001),
            "R7 hold while stalled", msg_data, mk(3'b010, 0, 0, 32'hA000_0001));
      @(negedge clk);
    end
    msg_ready = 1;
    expect_msg("R7 order first", mk(3'b010, 0, 0, 32'hA000_0001));
    expect_msg("R7 order second", mk(3'b010, 0, 0, 32'hA000_0002));
  endtask

  task automatic t_overflow(int ndrop, int exp_cnt);
    msg_ready = 0;
    for (int i = 0; i < 4; i++) ind(32'h100 + i);
    for (int i = 0; i < ndrop; i++) ind(32'h200 + i);
    msg_ready = 1;
    for (int i = 0; i < 4; i++)
      expect_msg("R8 held messages", mk(3'b010, 0, 0, 32'h100 + i));
    expect_msg("R8 loss notice", mk(3'b100, 5'(exp_cnt), 16'h0, 32'h0));
    expect_idle("R8 single notice");
    ind(32'h0000_3000);
    expect_msg("R8 resumes", mk(3'b010, 0, 0, 32'h0000_3000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_map_full();
    t_indirect();
    t_trap();
    t_stall();
    t_overflow(3, 3);
    t_overflow(40, 31);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule